// File: doc/BRIEF.md
# SDRAM Command Engine

This block sits between a simple single-word host port and a 4-bank SDRAM with a 16-bit data bus. Each host request carries a flat 23-bit word address. The engine splits that address into bank, row and column fields. It then drives one fixed command sequence on the memory pins: open the row, issue the column read or write, and close the row again with a single-bank precharge. No row stays open between requests. Every gap between commands is a cycle count derived from parameters. Write recovery is stretched so that it spans the active-to-precharge minimum less the row-to-column delay.

Read data comes back on the host side through a capture pipe. The pipe takes the data bus a CAS-latency number of cycles after the read command and adds a further fixed read pipe delay. A refresh controller outside this block asks for the memory through a request/grant pair. The engine grants it only while it is idle, which means every bank is precharged. The engine does not perform initialisation, and it has no pad logic.

Top module: `sdram_cmd_engine`

## Requirements
- R1: On the ACTIVE command, the bank pins carry addr[22:21] and A[11:0] carries addr[20:9]. On READ/WRITE, the bank pins carry the same bank and A carries {3'b000, addr[8:0]}, so A10 is low (no auto-precharge).
- R2: The command pins {cs_n, ras_n, cas_n, we_n} encode ACTIVE = 0011, READ = 0101, WRITE = 0100, PRECHARGE = 0010, NOP = 0111 (between the commands of one access) and deselect = 1111 (while idle). A request accepted in cycle c puts ACTIVE on the pins in cycle c+1.
- R3: READ or WRITE appears exactly 2 cycles after its ACTIVE.
- R4: PRECHARGE appears exactly 5 cycles after ACTIVE, for both reads and writes. This covers tRAS, and for writes it gives 3 cycles of write recovery after WRITE. It targets the same bank with A10 low.
- R5: Two ACTIVE commands are at least 7 cycles apart. This satisfies tRC = 6 and tRP = 2 after the precharge. ready_o is low from the ACTIVE cycle through the PRECHARGE cycle and may rise in the cycle after it.
- R6: ready_o is high exactly when the engine is idle and ref_req_i is low. A request is taken on a cycle with req_i and ready_o both high.
- R7: ref_gnt_o is high exactly when the engine is idle and ref_req_i is high. Refresh wins over a pending host request, and no grant is given during an access.
- R8: In the WRITE cycle only, dq_oe_o is high, dq_o carries the write data and dqm_o is the inverse of bmask_i. A bmask_i bit of 1 writes that byte, with bit 0 for the low byte. Outside the WRITE cycle, dqm_o and dq_oe_o are 0.
- R9: dqm_o is 00 during READ. rvalid_o pulses for one cycle 4 cycles after READ (CAS latency 2 plus a 2-cycle pipe). At that pulse, rdata_o equals dq_i as sampled in the cycle 2 cycles after READ.
- R10: During reset the pins show deselect, ready_o is high, and rvalid_o and dq_oe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 23 | Flat word address |
| wdata_i | input | 16 | Write data |
| bmask_i | input | 2 | Byte write enables, 1 = write byte |
| ready_o | output | 1 | Engine can take a request |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | 16 | Read data |
| ref_req_i | input | 1 | Refresh controller request |
| ref_gnt_o | output | 1 | Refresh grant |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank select |
| a_o | output | 12 | Row/column address |
| dqm_o | output | 2 | Data mask |
| dq_o | output | 16 | Write data to the bus |
| dq_oe_o | output | 1 | Data bus output enable |
| dq_i | input | 16 | Read data from the bus |

## Verification
A behavioural model predicts every pin value, ready, grant and read return for each cycle. Stimulus covers several patterns:
- Requests held back to back, which show the 7-cycle ACTIVE spacing.
- Requests separated by idle gaps, which show the return to deselect.
- The zero and all-ones addresses, which tell the field boundaries apart.
- Partial and empty byte masks followed by read-back, which show that the masks gate only the named byte.
- Refresh windows that fall inside an access and windows that collide with a waiting request, which separate no-grant-while-busy from refresh priority.

The bus carries changing junk in every cycle except the capture cycle, so a capture or valid pulse that is off by one cycle returns a wrong word.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACT   = 4'b0011,
    CMD_RD    = 4'b0101,
    CMD_WR    = 4'b0100,
    CMD_PRE   = 4'b0010,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_RW,
    ST_PRE
  } eng_st_e;

  function automatic int max2(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);
  assign {bank_o, row_o, col_o} = addr_i;
endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 2,
  parameter int RD_PIPE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_cmd_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [CAS_LAT-1:0] lat_q;
  logic [RD_PIPE-1:0] vld_q;
  logic [DATA_W-1:0]  dat_q [RD_PIPE];
  logic               cap;

  assign cap = lat_q[CAS_LAT-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      vld_q <= '0;
      for (int i = 0; i < RD_PIPE; i++) dat_q[i] <= '0;
    end else begin
      lat_q[0] <= rd_cmd_i;
      for (int i = 1; i < CAS_LAT; i++) lat_q[i] <= lat_q[i-1];
      vld_q[0] <= cap;
      if (cap) dat_q[0] <= dq_i;
      for (int i = 1; i < RD_PIPE; i++) begin
        vld_q[i] <= vld_q[i-1];
        dat_q[i] <= dat_q[i-1];
      end
    end
  end

  assign rvalid_o = vld_q[RD_PIPE-1];
  assign rdata_o  = dat_q[RD_PIPE-1];
endmodule

// File: rtl/sdram_cmd_engine.sv
module sdram_cmd_engine
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 9,
  parameter int A_W     = 12,
  parameter int DATA_W  = 16,
  parameter int T_RCD   = 2,
  parameter int T_RAS   = 5,
  parameter int T_RC    = 6,
  parameter int T_RP    = 2,
  parameter int T_WR    = 3,
  parameter int CAS_LAT = 2,
  parameter int RD_PIPE = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [BANK_W+ROW_W+COL_W-1:0] addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [DATA_W/8-1:0]         bmask_i,
  output logic                        ready_o,
  output logic                        rvalid_o,
  output logic [DATA_W-1:0]           rdata_o,
  input  logic                        ref_req_i,
  output logic                        ref_gnt_o,
  output logic                        cs_no,
  output logic                        ras_no,
  output logic                        cas_no,
  output logic                        we_no,
  output logic [BANK_W-1:0]           ba_o,
  output logic [A_W-1:0]              a_o,
  output logic [DATA_W/8-1:0]         dqm_o,
  output logic [DATA_W-1:0]           dq_o,
  output logic                        dq_oe_o,
  input  logic [DATA_W-1:0]           dq_i
);
  localparam int ADDR_W    = BANK_W + ROW_W + COL_W;
  localparam int MASK_W    = DATA_W / 8;
  // write recovery stretched to cover tRAS - tRCD
  localparam int G_PRE_WR  = max2(T_RAS - T_RCD, T_WR);
  localparam int G_PRE_RD  = max2(T_RAS - T_RCD, 1);
  localparam int G_IDLE_WR = max2(max2(T_RP, T_RC - T_RCD - G_PRE_WR) - 1, 1);
  localparam int G_IDLE_RD = max2(max2(T_RP, T_RC - T_RCD - G_PRE_RD) - 1, 1);
  localparam int G_MAX     = max2(max2(T_RCD, G_PRE_WR),
                                  max2(G_PRE_RD, max2(G_IDLE_WR, G_IDLE_RD)));
  localparam int CNT_W     = max2($clog2(G_MAX + 1), 1);

  eng_st_e             st_q;
  sd_cmd_e             cmd_q;
  logic [BANK_W-1:0]   ba_q;
  logic [A_W-1:0]      a_q;
  logic [MASK_W-1:0]   dqm_q, msk_q;
  logic [DATA_W-1:0]   dq_q, wd_q;
  logic                oe_q, we_q;
  logic [COL_W-1:0]    col_q;

  logic [BANK_W-1:0]   bank_w;
  logic [ROW_W-1:0]    row_w;
  logic [COL_W-1:0]    col_w;
  logic                accept, tmr_zero, tmr_load;
  logic [CNT_W-1:0]    tmr_val;

  sdram_addr_split #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
  ) u_split (
    .addr_i(addr_i), .bank_o(bank_w), .row_o(row_w), .col_o(col_w)
  );

  assign ready_o   = (st_q == ST_IDLE) && !ref_req_i;
  assign ref_gnt_o = (st_q == ST_IDLE) && ref_req_i;
  assign accept    = req_i && ready_o;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RCD - 1);
      end
      ST_ACT: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = we_q ? CNT_W'(G_PRE_WR - 1) : CNT_W'(G_PRE_RD - 1);
      end
      ST_RW: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = we_q ? CNT_W'(G_IDLE_WR - 1) : CNT_W'(G_IDLE_RD - 1);
      end
      default: ;
    endcase
  end

  sdram_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cmd_q <= CMD_DESEL;
      ba_q  <= '0;
      a_q   <= '0;
      dqm_q <= '0;
      dq_q  <= '0;
      oe_q  <= 1'b0;
      we_q  <= 1'b0;
      col_q <= '0;
      wd_q  <= '0;
      msk_q <= '0;
    end else begin
      oe_q  <= 1'b0;
      dqm_q <= '0;
      unique case (st_q)
        ST_IDLE: begin
          cmd_q <= CMD_DESEL;
          if (accept) begin
            cmd_q <= CMD_ACT;
            ba_q  <= bank_w;
            a_q   <= A_W'(row_w);
            we_q  <= we_i;
            col_q <= col_w;
            wd_q  <= wdata_i;
            msk_q <= bmask_i;
            st_q  <= ST_ACT;
          end
        end
        ST_ACT: begin
          cmd_q <= CMD_NOP;
          if (tmr_zero) begin
            cmd_q <= we_q ? CMD_WR : CMD_RD;
            a_q   <= A_W'(col_q);   // A10 low: no auto-precharge
            if (we_q) begin
              oe_q  <= 1'b1;
              dq_q  <= wd_q;
              dqm_q <= ~msk_q;
            end
            st_q  <= ST_RW;
          end
        end
        ST_RW: begin
          cmd_q <= CMD_NOP;
          if (tmr_zero) begin
            cmd_q <= CMD_PRE;     // single bank, A10 low
            a_q   <= '0;
            st_q  <= ST_PRE;
          end
        end
        default: begin
          cmd_q <= CMD_NOP;
          if (tmr_zero) begin
            cmd_q <= CMD_DESEL;
            st_q  <= ST_IDLE;
          end
        end
      endcase
    end
  end

  sdram_rd_pipe #(
    .DATA_W(DATA_W), .CAS_LAT(CAS_LAT), .RD_PIPE(RD_PIPE)
  ) u_rd_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_cmd_i(cmd_q == CMD_RD),
    .dq_i(dq_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o)
  );

  assign {cs_no, ras_no, cas_no, we_no} = cmd_q;
  assign ba_o    = ba_q;
  assign a_o     = a_q;
  assign dqm_o   = dqm_q;
  assign dq_o    = dq_q;
  assign dq_oe_o = oe_q;
endmodule

// File: rtl/sdram_cmd_engine_chk.sv
module sdram_cmd_engine_chk #(
  parameter int T_RCD  = 2,
  parameter int T_RAS  = 5,
  parameter int T_RC   = 6,
  parameter int T_RP   = 2,
  parameter int MASK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              ref_req_i,
  input logic              ref_gnt_o,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [MASK_W-1:0] dqm_o,
  input logic              dq_oe_o,
  input logic              rvalid_o
);
  logic [3:0] cmd;
  logic       is_act, is_rd, is_wr, is_pre;
  logic [7:0] since_act;
  logic       seen_act;

  assign cmd    = {cs_no, ras_no, cas_no, we_no};
  assign is_act = (cmd == 4'b0011);
  assign is_rd  = (cmd == 4'b0101);
  assign is_wr  = (cmd == 4'b0100);
  assign is_pre = (cmd == 4'b0010);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act <= '0;
      seen_act  <= 1'b0;
    end else if (is_act) begin
      since_act <= 8'd1;
      seen_act  <= 1'b1;
    end else if (since_act != 8'hFF) begin
      since_act <= since_act + 8'd1;
    end
  end

  a_r3_rw_after_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd || is_wr) |-> (int'(since_act) == T_RCD));

  a_r4_pre_after_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> (int'(since_act) == T_RAS));

  a_r5_act_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act && seen_act) |-> (int'(since_act) >= T_RC && int'(since_act) >= T_RAS + T_RP));

  a_r6_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cs_no);

  a_r7_gnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_gnt_o |-> (ref_req_i && !ready_o && cs_no));

  a_r8_oe_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> is_wr);

  a_r9_read_dqm_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rd |-> (dqm_o == '0));

  a_r9_rvalid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
endmodule

bind sdram_cmd_engine sdram_cmd_engine_chk #(
  .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP), .MASK_W(MASK_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ready_o(ready_o), .ref_req_i(ref_req_i),
  .ref_gnt_o(ref_gnt_o), .cs_no(cs_no), .ras_no(ras_no), .cas_no(cas_no),
  .we_no(we_no), .dqm_o(dqm_o), .dq_oe_o(dq_oe_o), .rvalid_o(rvalid_o)
);

// File: tb/sdram_cmd_engine_bench.sv
module sdram_cmd_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_NOP = 4'b0111, C_DES = 4'b1111;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, ref_req = 1'b0;
  logic [22:0] addr = '0;
  logic [15:0] wdata = '0, dq_in = '0;
  logic [1:0]  bmask = '0;
  logic        ready, rvalid, ref_gnt, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [15:0] rdata, dq_out;
  logic [1:0]  ba, dqm;
  logic [11:0] a;

  sdram_cmd_engine u_sdram_cmd_engine (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .bmask_i(bmask), .ready_o(ready), .rvalid_o(rvalid),
    .rdata_o(rdata), .ref_req_i(ref_req), .ref_gnt_o(ref_gnt),
    .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .ba_o(ba), .a_o(a), .dqm_o(dqm), .dq_o(dq_out), .dq_oe_o(dq_oe),
    .dq_i(dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        w;
    logic [22:0] ad;
    logic [15:0] d;
    logic [1:0]  m;
    int          gap;
  } req_t;

  req_t        rq[$];
  logic [3:0]  e_cmd [int];
  logic [1:0]  e_ba  [int];
  logic [11:0] e_a   [int];
  logic [1:0]  e_dqm [int];
  logic [15:0] e_dq  [int];
  logic [15:0] e_rd  [int];
  logic [15:0] drv   [int];
  logic [15:0] mem   [int];
  int acc_start = -100, acc_end = -100;
  int nvec = 0, nerr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_rd(input logic [22:0] ad);
    if (mem.exists(int'(ad))) return mem[int'(ad)];
    return ad[15:0] ^ 16'hA5C3;
  endfunction

  function automatic bit ref_win(input int c);
    return (c >= 9 && c <= 11) || (c >= 40 && c <= 52) || (c >= 100 && c <= 104);
  endfunction

  task automatic push(input logic w, input logic [22:0] ad, input logic [15:0] d,
                      input logic [1:0] m, input int gap);
    req_t r;
    r.w = w; r.ad = ad; r.d = d; r.m = m; r.gap = gap;
    rq.push_back(r);
  endtask

  task automatic schedule(input int c, input req_t r);
    int ac, rw;
    logic [15:0] v;
    ac = c + 1;
    rw = ac + 2;
    e_cmd[ac] = C_ACT; e_ba[ac] = r.ad[22:21]; e_a[ac] = r.ad[20:9];
    e_cmd[rw] = r.w ? C_WR : C_RD; e_ba[rw] = r.ad[22:21]; e_a[rw] = {3'b000, r.ad[8:0]};
    v = mem_rd(r.ad);
    if (r.w) begin
      e_dqm[rw] = ~r.m;
      e_dq[rw]  = r.d;
      if (r.m[0]) v[7:0]  = r.d[7:0];
      if (r.m[1]) v[15:8] = r.d[15:8];
      mem[int'(r.ad)] = v;
    end else begin
      drv[rw + 2]  = v;
      e_rd[rw + 4] = v;
    end
    e_cmd[ac + 5] = C_PRE; e_ba[ac + 5] = r.ad[22:21];
    acc_start = ac;
    acc_end   = ac + 5;
  endtask

  bit exp_ready;

  task automatic compare(input int c);
    logic [3:0] ec, ac;
    bit in_acc;
    logic [1:0] edqm;
    bit eoe;
    ac = {cs_n, ras_n, cas_n, we_n};
    in_acc = (c >= acc_start) && (c <= acc_end);
    ec = e_cmd.exists(c) ? e_cmd[c] : (in_acc ? C_NOP : C_DES);
    case (ec)
      C_ACT: chk(ac == ec, "R2 ACTIVE cmd", 32'(ac), 32'(ec));
      C_RD, C_WR: chk(ac == ec, "R3 READ/WRITE cmd", 32'(ac), 32'(ec));
      C_PRE: chk(ac == ec, "R4 PRECHARGE cmd", 32'(ac), 32'(ec));
      C_NOP: chk(ac == ec, "R5 NOP gap", 32'(ac), 32'(ec));
      default: chk(ac == ec, "R2 idle deselect", 32'(ac), 32'(ec));
    endcase
    exp_ready = !in_acc && !ref_req;
    chk(ready == exp_ready, "R6 ready", 32'(ready), 32'(exp_ready));
    chk(ref_gnt == (!in_acc && ref_req), "R7 ref_gnt", 32'(ref_gnt), 32'(!in_acc && ref_req));
    if (ec == C_ACT || ec == C_RD || ec == C_WR) begin
      chk(ba == e_ba[c], "R1 bank", 32'(ba), 32'(e_ba[c]));
      chk(a == e_a[c], "R1 row/column on A", 32'(a), 32'(e_a[c]));
    end
    if (ec == C_PRE) begin
      chk(ba == e_ba[c], "R4 precharge bank", 32'(ba), 32'(e_ba[c]));
      chk(a[10] == 1'b0, "R4 A10 low", 32'(a[10]), 32'(0));
    end
    edqm = e_dqm.exists(c) ? e_dqm[c] : 2'b00;
    if (ec == C_RD) chk(dqm == 2'b00, "R9 dqm on read", 32'(dqm), 32'(0));
    else chk(dqm == edqm, "R8 dqm", 32'(dqm), 32'(edqm));
    eoe = (ec == C_WR);
    chk(dq_oe == eoe, "R8 dq_oe", 32'(dq_oe), 32'(eoe));
    if (eoe) chk(dq_out == e_dq[c], "R8 write data", 32'(dq_out), 32'(e_dq[c]));
    chk(rvalid == e_rd.exists(c), "R9 rvalid", 32'(rvalid), 32'(e_rd.exists(c)));
    if (e_rd.exists(c)) chk(rdata == e_rd[c], "R9 rdata", 32'(rdata), 32'(e_rd[c]));
  endtask

  initial begin
    int wait_cnt;
    bit presenting;
    req_t r;
    push(1'b1, 23'h000000, 16'h1234, 2'b11, 0);  // zero address
    push(1'b0, 23'h000000, 16'h0000, 2'b00, 0);  // back to back
    push(1'b1, 23'h7FFFFF, 16'hABCD, 2'b11, 2);  // all-ones address
    push(1'b0, 23'h7FFFFF, 16'h0000, 2'b00, 0);
    push(1'b1, 23'h1AB3C5, 16'hBEEF, 2'b01, 1);  // low byte only
    push(1'b1, 23'h1AB3C5, 16'h55AA, 2'b10, 0);  // high byte only
    push(1'b0, 23'h1AB3C5, 16'h0000, 2'b00, 3);
    push(1'b0, 23'h400201, 16'h0000, 2'b00, 0);  // never written
    push(1'b1, 23'h600000, 16'hFFFF, 2'b00, 0);  // empty mask
    push(1'b0, 23'h600000, 16'h0000, 2'b00, 0);
    push(1'b1, 23'h2001FF, 16'hC001, 2'b11, 4);
    push(1'b0, 23'h2001FF, 16'h0000, 2'b00, 4);
    push(1'b1, 23'h5FFE00, 16'h0F0F, 2'b11, 0);
    push(1'b0, 23'h5FFE00, 16'h0000, 2'b00, 6);
    push(1'b0, 23'h000000, 16'h0000, 2'b00, 0);

    repeat (2) @(negedge clk);
    // R10 reset state
    chk({cs_n, ras_n, cas_n, we_n} == C_DES, "R10 reset deselect", 32'({cs_n, ras_n, cas_n, we_n}), 32'(C_DES));
    chk(ready == 1'b1, "R10 reset ready", 32'(ready), 32'(1));
    chk(rvalid == 1'b0, "R10 reset rvalid", 32'(rvalid), 32'(0));
    chk(dq_oe == 1'b0, "R10 reset dq_oe", 32'(dq_oe), 32'(0));
    rst_ni = 1'b1;

    wait_cnt = rq[0].gap;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      ref_req = ref_win(c);
      presenting = (rq.size() > 0) && (wait_cnt == 0);
      if (presenting) begin
        r = rq[0];
        req = 1'b1; we = r.w; addr = r.ad; wdata = r.d; bmask = r.m;
      end else begin
        req = 1'b0; we = 1'b0; addr = 23'h2AAAAA; wdata = 16'h0; bmask = 2'b00;
      end
      dq_in = drv.exists(c) ? drv[c] : (16'hD00D ^ 16'(c));
      #1;
      compare(c);
      if (presenting && exp_ready) begin
        schedule(c, rq[0]);
        void'(rq.pop_front());
        wait_cnt = (rq.size() > 0) ? rq[0].gap : 0;
      end else if (!presenting && wait_cnt > 0) begin
        wait_cnt--;
      end
    end
    chk(rq.size() == 0, "R6 all requests taken", 32'(rq.size()), 32'(0));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL R6 watchdog expired actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule